// File: doc/BRIEF.md
# Cascadable Presettable Up-Counter

This block is a small synchronous up-counter with a parallel preset. The count advances on the rising clock edge. Two elaboration switches shape it. One picks binary counting, which wraps after the all-ones value, or decade counting, which wraps after nine. The other picks whether the active-low clear takes effect at once or only at a clock edge.

The counter steps only when both active-high enables are high. A low load input replaces the count with the parallel data at the next rising edge. The carry output is high when the terminal value is reached, and only the second enable gates it. A stage's carry can therefore drive the gating enable of the next stage, with no register in between. Wider counters are built this way.

Top module: `presettable_counter`

## Requirements
- R1: With DECADE=0 and CNT_W=4, an enabled count steps by one and wraps from 15 to 0 (from 12: 13, 14, 15, 0).
- R2: With DECADE=1, an enabled count wraps from 9 to 0 (from 7: 8, 9, 0).
- R3: When `clr_n` is high and `load_n` is low, `q` takes `din` at the rising edge, whatever the two enables are.
- R4: When `clr_n` and `load_n` are high and either `cnt_en` or `chain_en` is low, `q` is unchanged across the edge.
- R5: `clr_n` low has priority over load and over counting. With ASYNC_CLR=1, `q` becomes 0 as soon as `clr_n` falls, without waiting for a clock edge.
- R6: With ASYNC_CLR=0, `q` keeps its value while `clr_n` is low between edges, and becomes 0 at the next rising edge.
- R7: `carry` is high exactly when `chain_en` is high and `q` equals the terminal value (15 in binary mode, 9 in decade mode). `cnt_en` has no effect on `carry`.
- R8: `carry` follows `chain_en` within the same cycle, with no clock edge in between.
- R9: In decade mode, a loaded value from 10 to 15 steps by one per enabled edge and reaches 0 after 15. `carry` stays low for all of these values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; active on the rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous as set by ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable; does not affect carry |
| chain_en | input | 1 | Count enable that also gates carry |
| din | input | CNT_W | Parallel preset data |
| q | output | CNT_W | Registered count |
| carry | output | 1 | Terminal-count flag, gated by chain_en |

## Verification
The clocked properties assume that `clr_n` is held low through the first rising edge, so the count is known before any of them is evaluated. They also assume that the control inputs change only away from the rising edge. The stimulus meets both conditions. It drives every input at the falling edge and releases the clear there, which makes the release synchronous even for the asynchronous variant. The only inputs that move between edges are the mid-cycle clear and the `chain_en` toggles, and no clocked property samples either of them during that time.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_STEP = 2'd2
   } pcnt_op_e;

   function automatic int unsigned wrap_value(input bit decade, input int unsigned width);
      return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
   endfunction

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
   import pcnt_pkg::*;
(
   input  logic     load_n,
   input  logic     cnt_en,
   input  logic     chain_en,
   output pcnt_op_e op
);
   always_comb begin
      if (!load_n)
         op = OP_LOAD;
      else if (cnt_en && chain_en)
         op = OP_STEP;
      else
         op = OP_HOLD;
   end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
   import pcnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter bit          DECADE = 1'b0
) (
   input  pcnt_op_e         op,
   input  logic [CNT_W-1:0] cur,
   input  logic [CNT_W-1:0] din,
   output logic [CNT_W-1:0] nxt
);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(wrap_value(DECADE, CNT_W));

   logic [CNT_W-1:0] stepped;

   generate
      if (DECADE) begin : g_decade
         always_comb stepped = (cur == TERM) ? '0 : cur + 1'b1;
      end else begin : g_binary
         always_comb stepped = cur + 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_LOAD: nxt = din;
         OP_STEP: nxt = stepped;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/pcnt_state.sv
module pcnt_state #(
   parameter int unsigned CNT_W     = 4,
   parameter bit          ASYNC_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [CNT_W-1:0] nxt,
   output logic [CNT_W-1:0] cur
);
   generate
      if (ASYNC_CLR) begin : g_async
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) cur <= '0;
            else        cur <= nxt;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!clr_n) cur <= '0;
            else        cur <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry
   import pcnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter bit          DECADE = 1'b0
) (
   input  logic [CNT_W-1:0] cur,
   input  logic             chain_en,
   output logic             carry
);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(wrap_value(DECADE, CNT_W));

   logic at_term;
   always_comb at_term = (cur == TERM);
   always_comb carry   = chain_en & at_term;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
   import pcnt_pkg::*;
#(
   parameter int unsigned CNT_W     = 4,
   parameter bit          DECADE    = 1'b0,
   parameter bit          ASYNC_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             cnt_en,
   input  logic             chain_en,
   input  logic [CNT_W-1:0] din,
   output logic [CNT_W-1:0] q,
   output logic             carry
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("presettable_counter: CNT_W must be at least 2");
      end
      if (DECADE && CNT_W != 4) begin : g_bad_decade
         $error("presettable_counter: decade mode needs CNT_W of 4");
      end
   endgenerate

   pcnt_op_e         op;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] cur;

   pcnt_ctrl u_ctrl (
      .load_n   (load_n),
      .cnt_en   (cnt_en),
      .chain_en (chain_en),
      .op       (op)
   );

   pcnt_next #(.CNT_W(CNT_W), .DECADE(DECADE)) u_next (
      .op  (op),
      .cur (cur),
      .din (din),
      .nxt (nxt)
   );

   pcnt_state #(.CNT_W(CNT_W), .ASYNC_CLR(ASYNC_CLR)) u_state (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .cur   (cur)
   );

   pcnt_carry #(.CNT_W(CNT_W), .DECADE(DECADE)) u_carry (
      .cur      (cur),
      .chain_en (chain_en),
      .carry    (carry)
   );

   assign q = cur;
endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
   parameter int unsigned CNT_W     = 4,
   parameter bit          DECADE    = 1'b0,
   parameter bit          ASYNC_CLR = 1'b1
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic             cnt_en,
   input logic             chain_en,
   input logic [CNT_W-1:0] din,
   input logic [CNT_W-1:0] q,
   input logic             carry
);
   localparam logic [CNT_W-1:0] LAST = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

   // R3: load wins over enables
   assert_load_takes_data_R3: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> q == $past(din));

   // R4: either enable low holds the count
   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(cnt_en && chain_en)) |=> $stable(q));

   // R1 and R2: step with wrap after the terminal value
   assert_step_wraps_R1: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cnt_en && chain_en) |=>
         q == (($past(q) == LAST) ? '0 : $past(q) + 1'b1));

   // R5 and R6: a low clear at an edge leaves zero behind it
   assert_clear_zeroes_R5: assert property (@(posedge clk)
      !clr_n |=> q == '0);

   // R7: carry only while the gating enable is high
   assert_carry_gated_R7: assert property (@(posedge clk) disable iff (!clr_n)
      carry |-> chain_en && q == LAST);

   // R9: no carry for decade values above nine
   assert_no_carry_over_nine_R9: assert property (@(posedge clk) disable iff (!clr_n)
      (DECADE && q > CNT_W'(9)) |-> !carry);
endmodule

bind presettable_counter pcnt_checker #(
   .CNT_W(CNT_W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_pcnt_checker (
   .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
   .chain_en(chain_en), .din(din), .q(q), .carry(carry)
);

// File: tb/presettable_counter_test.sv
module presettable_counter_test;
   localparam int CLK_PERIOD = 10;
   localparam int NROWS = 15;

   typedef struct packed {
      logic       clr_n;
      logic       load_n;
      logic       en_p;
      logic       en_t;
      logic [3:0] din;
      logic [3:0] qb;
      logic       cb;
      logic [3:0] qd;
      logic       cd;
   } row_t;

   // clr ld ep et din | bin q,c | dec q,c
   localparam row_t VEC [NROWS] = '{
      '{1'b1,1'b0,1'b0,1'b0,4'd12, 4'd12,1'b0, 4'd12,1'b0}, // R3 load 12; R9 decade out of range
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd13,1'b0, 4'd13,1'b0}, // R1 R9
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd14,1'b0, 4'd14,1'b0},
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd15,1'b1, 4'd15,1'b0}, // R7 binary terminal, R9 no decade carry
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd0, 1'b0, 4'd0, 1'b0}, // R1 wrap, R9 wrap
      '{1'b1,1'b0,1'b1,1'b1,4'd7,  4'd7, 1'b0, 4'd7, 1'b0}, // R3 load beats enables
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd8, 1'b0, 4'd8, 1'b0}, // R2
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd9, 1'b0, 4'd9, 1'b1}, // R2 R7 decade terminal
      '{1'b1,1'b1,1'b0,1'b1,4'd0,  4'd9, 1'b0, 4'd9, 1'b1}, // R4 R7 cnt_en low, carry kept
      '{1'b1,1'b1,1'b1,1'b0,4'd0,  4'd9, 1'b0, 4'd9, 1'b0}, // R4 R7 chain_en low
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd10,1'b0, 4'd0, 1'b0}, // R2 wrap 9 to 0
      '{1'b1,1'b0,1'b0,1'b0,4'd15, 4'd15,1'b0, 4'd15,1'b0}, // R3
      '{1'b1,1'b1,1'b0,1'b1,4'd0,  4'd15,1'b1, 4'd15,1'b0}, // R4 R7 R9
      '{1'b0,1'b0,1'b1,1'b1,4'd5,  4'd0, 1'b0, 4'd0, 1'b0}, // R5 clear beats load
      '{1'b1,1'b1,1'b1,1'b1,4'd0,  4'd1, 1'b0, 4'd1, 1'b0}  // R1 R2
   };

   logic       clk = 1'b0;
   logic       clr_n, load_n, en_p, en_t;
   logic [3:0] din;
   logic [3:0] qb, qd;
   logic       cb, cd;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   presettable_counter #(.CNT_W(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) uut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en_p),
      .chain_en(en_t), .din(din), .q(qb), .carry(cb)
   );

   presettable_counter #(.CNT_W(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) uut_dec (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en_p),
      .chain_en(en_t), .din(din), .q(qd), .carry(cd)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clr_n = 1'b0; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      clr_n = 1'b1;
      #1;
      chk("R5 reset bin q", qb, 4'd0);
      chk("R5 reset dec q", qd, 4'd0);
      chk("R7 reset bin carry", {3'b0, cb}, 4'd0);
      chk("R7 reset dec carry", {3'b0, cd}, 4'd0);

      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         clr_n = VEC[i].clr_n; load_n = VEC[i].load_n;
         en_p = VEC[i].en_p;   en_t = VEC[i].en_t; din = VEC[i].din;
         @(posedge clk);
         #1;
         chk($sformatf("R1/R3/R4 row %0d bin q", i), qb, VEC[i].qb);
         chk($sformatf("R7 row %0d bin carry", i), {3'b0, cb}, {3'b0, VEC[i].cb});
         chk($sformatf("R2/R9 row %0d dec q", i), qd, VEC[i].qd);
         chk($sformatf("R7/R9 row %0d dec carry", i), {3'b0, cd}, {3'b0, VEC[i].cd});
      end

      // R5 / R6: clear dropped between edges
      @(negedge clk);
      load_n = 1'b0; din = 4'd9; en_p = 1'b0; en_t = 1'b0;
      @(posedge clk); #1;
      chk("R3 load 9 bin", qb, 4'd9);
      chk("R3 load 9 dec", qd, 4'd9);
      @(negedge clk);
      load_n = 1'b1; clr_n = 1'b0;
      #1;
      chk("R5 async clear immediate", qb, 4'd0);
      chk("R6 sync clear waits for edge", qd, 4'd9);
      @(posedge clk); #1;
      chk("R6 sync clear at edge", qd, 4'd0);
      @(negedge clk);
      clr_n = 1'b1;

      // R8: carry follows chain_en combinationally
      @(negedge clk);
      load_n = 1'b0; din = 4'd9;
      @(posedge clk); #1;
      @(negedge clk);
      load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
      #1;
      chk("R8 dec carry low with chain_en low", {3'b0, cd}, 4'd0);
      en_t = 1'b1;
      #1;
      chk("R8 dec carry follows chain_en", {3'b0, cd}, 4'd1);
      chk("R7 bin no carry at 9", {3'b0, cb}, 4'd0);
      @(posedge clk); #1;
      chk("R4 dec hold with cnt_en low", qd, 4'd9);
      @(negedge clk);
      load_n = 1'b0; din = 4'd15;
      @(posedge clk); #1;
      chk("R9 dec carry low at 15", {3'b0, cd}, 4'd0);
      chk("R8 bin carry at 15", {3'b0, cb}, 4'd1);
      @(negedge clk);
      load_n = 1'b1; en_t = 1'b0;
      #1;
      chk("R8 bin carry drops with chain_en", {3'b0, cb}, 4'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule